// File: doc/BRIEF.md
# Interrupt Coalescing Credit Controller

This block manages a configurable number of interrupt vectors for a datapath. Each vector keeps a signed credit count that rises by one with every event pulse from the datapath. Each vector also keeps a mask bit, a value that is copied into the mask whenever the vector fires, and a coalescing timer. The timer counts down from a programmable start value, once per tick of a shared prescaler. A vector raises its interrupt line when it has positive credits, is unmasked and its timer has run out.

Software reaches every vector through a flat register window of eight 32-bit words per vector. A single write to the credit word does three things at once. It returns serviced credits by subtracting the count field. It can unmask the vector. It can restart the coalescing timer. With this one write, a handler can finish its work and re-arm the vector without a race.

The register bus is a plain single-cycle port: a write completes on the clock edge where `bus_wr` is high, and read data is a combinational function of `bus_addr`. Every access therefore completes at once, and the block has no valid/ready handshake and applies no back-pressure. Event pulses are plain per-vector strobes and are never refused.

Top module: `irq_coal_ctrl`

## Requirements
- R1: After reset, every interrupt line is low. Every vector's mask and mask-on-fire words read 1. Its credit, start value and remaining-time words read 0.
- R2: The word address is vector*8 + offset. The offsets are: 0 start value, 1 mask (bit 0), 2 credits, 3 mask-on-fire (bit 0), 4 remaining time. Offsets 5, 6 and 7 read 0 and ignore writes. A write to one vector changes no other vector.
- R3: A start value written above 63 is stored as 63. Values from 0 to 63 are stored as written.
- R4: Each event pulse adds 1 to the vector's credits. A write to the credit word subtracts bits [14:0] of the written data in the same cycle as any event. The credit word reads the 16-bit two's-complement count in bits [15:0], with zeros above it.
- R5: In a credit write, bit 16 clears the mask and bit 17 reloads the timer from the start value. Setting both bits re-arms the vector. A count of zero with neither flag set leaves the vector unchanged.
- R6: The prescaler produces one tick every `tick_div`+1 cycles. On each tick a nonzero timer decrements by one. A timer at zero stays at zero.
- R7: When a vector's credits are above zero, its mask is 0 and its timer is 0, its interrupt line is high in the following cycle. On the same edge, the mask takes the mask-on-fire value. With mask-on-fire at 1 this gives a single-cycle pulse. With mask-on-fire at 0 the line stays high while the conditions hold.
- R8: Addresses of vectors at or beyond the vector count read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, applied on the clock edge |
| bus_addr | input | ADDR_W | Word address (vector*8 + offset) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| evt | input | NUM_VEC | Per-vector event pulse, one credit per cycle high |
| tick_div | input | DIV_W | Prescaler divide value (tick every tick_div+1 cycles) |
| irq_out | output | NUM_VEC | Per-vector interrupt line |

## Verification
The credit path is driven with a return larger than the held count, which shows whether the count really goes negative. It is then driven with enough events to climb back above zero, which shows whether the sign is honoured. It is also driven with an event and a return in the same cycle, which shows whether both are applied. Firing is tried in three ways:
- with the timer already at zero, where only the unmask should trigger it;
- after a full re-arm, where the pulse must land exactly one cycle after the timer empties;
- with mask-on-fire cleared, which separates a one-shot pulse from a level that holds until the credits are returned.

Unmapped offsets and vectors are written with all ones and read back. The neighbouring registers are then read to show the write did not leak.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;
  localparam int DATA_W      = 32;
  localparam int CRED_W      = 16;
  localparam int COAL_W      = 6;
  localparam int COAL_MAX    = 63;
  localparam int UNMASK_BIT  = 16;
  localparam int RESTART_BIT = 17;

  localparam logic [2:0] OFF_INIT   = 3'd0;
  localparam logic [2:0] OFF_MASK   = 3'd1;
  localparam logic [2:0] OFF_CRED   = 3'd2;
  localparam logic [2:0] OFF_MFIRE  = 3'd3;
  localparam logic [2:0] OFF_REMAIN = 3'd4;
endpackage

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= div;
    else           cnt_q <= cnt_q - 1'b1;
  end

  // R6
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> !tick);
endmodule

// File: rtl/irq_vector.sv
module irq_vector
  import irq_coal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              evt,
  input  logic              wr_en,
  input  logic [2:0]        wr_off,
  input  logic [DATA_W-1:0] wdata,
  input  logic [2:0]        rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic [COAL_W-1:0] init_q, timer_q;
  logic [CRED_W-1:0] cred_q, cred_d, ret;
  logic              mask_q, mfire_q;
  logic              wr_init, wr_mask, wr_cred, wr_mfire;
  logic              restart, unmask, cred_pos, fire;
  logic              unused_hi;

  assign unused_hi = ^wdata[DATA_W-1:RESTART_BIT+1];

  assign wr_init  = wr_en && (wr_off == OFF_INIT);
  assign wr_mask  = wr_en && (wr_off == OFF_MASK);
  assign wr_cred  = wr_en && (wr_off == OFF_CRED);
  assign wr_mfire = wr_en && (wr_off == OFF_MFIRE);
  assign restart  = wr_cred && wdata[RESTART_BIT];
  assign unmask   = wr_cred && wdata[UNMASK_BIT];

  assign cred_pos = !cred_q[CRED_W-1] && (cred_q != '0);
  assign fire     = cred_pos && !mask_q && (timer_q == '0);
  assign ret      = wr_cred ? {1'b0, wdata[CRED_W-2:0]} : '0;
  assign cred_d   = cred_q + CRED_W'(evt) - ret;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q  <= '0;
      timer_q <= '0;
      mask_q  <= 1'b1;
      mfire_q <= 1'b1;
      cred_q  <= '0;
      irq     <= 1'b0;
    end else begin
      irq    <= fire;
      cred_q <= cred_d;
      if (wr_init)
        init_q <= (wdata > DATA_W'(COAL_MAX)) ? COAL_W'(COAL_MAX) : wdata[COAL_W-1:0];
      if (wr_mfire) mfire_q <= wdata[0];
      if (wr_mask)     mask_q <= wdata[0];
      else if (unmask) mask_q <= 1'b0;
      else if (fire)   mask_q <= mfire_q;
      if (restart)                      timer_q <= init_q;
      else if (tick && timer_q != '0)   timer_q <= timer_q - 1'b1;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_off)
      OFF_INIT:   rd_data = DATA_W'(init_q);
      OFF_MASK:   rd_data = DATA_W'(mask_q);
      OFF_CRED:   rd_data = DATA_W'(cred_q);
      OFF_MFIRE:  rd_data = DATA_W'(mfire_q);
      OFF_REMAIN: rd_data = DATA_W'(timer_q);
      default:    rd_data = '0;
    endcase
  end

  // R7
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !wr_mask && !unmask) |=> (mask_q == $past(mfire_q)));
  // R4
  cred_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !wr_cred) |=> (cred_q == $past(cred_q) + CRED_W'(1)));
  // R6
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(timer_q));
  // R6
  timer_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_q == '0 && !restart) |=> (timer_q == '0));
endmodule

// File: rtl/irq_coal_ctrl.sv
module irq_coal_ctrl
  import irq_coal_pkg::*;
#(
  parameter int NUM_VEC = 4,
  parameter int ADDR_W  = 6,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_VEC-1:0] evt,
  input  logic [DIV_W-1:0]   tick_div,
  output logic [NUM_VEC-1:0] irq_out
);
  localparam int VEC_W = ADDR_W - 3;

  logic [VEC_W-1:0]  vec_idx;
  logic [2:0]        off;
  logic              tick;
  logic [DATA_W-1:0] rd_vec [NUM_VEC];
  logic              in_range;

  assign vec_idx  = bus_addr[ADDR_W-1:3];
  assign off      = bus_addr[2:0];
  assign in_range = (32'(vec_idx) < NUM_VEC);

  irq_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk (clk), .rst_n (rst_n), .div (tick_div), .tick (tick)
  );

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
    irq_vector u_vec (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .evt     (evt[i]),
      .wr_en   (bus_wr && (vec_idx == VEC_W'(i))),
      .wr_off  (off),
      .wdata   (bus_wdata),
      .rd_off  (off),
      .rd_data (rd_vec[i]),
      .irq     (irq_out[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_VEC; i++)
      if (vec_idx == VEC_W'(i)) bus_rdata = rd_vec[i];
  end

  always_comb begin
    // R8
    range_zero_chk: assert (in_range || bus_rdata == '0);
  end
endmodule

// File: tb/irq_coal_ctrl_bench.sv
module irq_coal_ctrl_bench;
  localparam int NV = 4;
  localparam int AW = 6;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NV-1:0] evt = '0;
  logic [DW-1:0] tick_div = '0;
  logic [NV-1:0] irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  irq_coal_ctrl #(.NUM_VEC(NV), .ADDR_W(AW), .DIV_W(DW)) u_irq_coal_ctrl (
    .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .evt, .tick_div, .irq_out
  );

  always #5 clk = ~clk;

  function automatic logic [AW-1:0] ad(int v, int o);
    return AW'(v * 8 + o);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(int v, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); evt[v] = 1'b1;
      @(negedge clk); evt[v] = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", 32'(irq_out), 0);
    for (int v = 0; v < NV; v++) begin
      rd(ad(v, 0), d); chk("R1 init", d, 0);
      rd(ad(v, 1), d); chk("R1 mask", d, 1);
      rd(ad(v, 2), d); chk("R1 credits", d, 0);
      rd(ad(v, 3), d); chk("R1 mask-on-fire", d, 1);
      rd(ad(v, 4), d); chk("R1 remain", d, 0);
    end
  endtask

  task automatic t_clamp;
    logic [31:0] d;
    wr(ad(0, 0), 200);   rd(ad(0, 0), d); chk("R3 clamp", d, 63);
    wr(ad(0, 0), 32'h25); rd(ad(0, 0), d); chk("R3 in range", d, 32'h25);
    rd(ad(1, 0), d); chk("R2 other vector", d, 0);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    for (int o = 5; o < 8; o++) begin
      wr(ad(0, o), 32'hFFFF_FFFF);
      rd(ad(0, o), d); chk("R2 reserved", d, 0);
    end
    rd(ad(0, 0), d); chk("R2 init kept", d, 32'h25);
    rd(ad(0, 1), d); chk("R2 mask kept", d, 1);
    rd(ad(0, 2), d); chk("R2 credits kept", d, 0);
  endtask

  task automatic t_range;
    logic [31:0] d;
    wr(ad(5, 1), 0);
    wr(ad(6, 2), 32'h0003_7FFF);
    rd(ad(5, 1), d); chk("R8 read zero", d, 0);
    rd(ad(6, 2), d); chk("R8 read zero", d, 0);
    rd(ad(1, 1), d); chk("R8 no alias mask", d, 1);
    rd(ad(2, 2), d); chk("R8 no alias credits", d, 0);
  endtask

  task automatic t_credits;
    logic [31:0] d;
    wr(ad(3, 2), 5);
    rd(ad(3, 2), d); chk("R4 negative", d, 32'h0000_FFFB);
    pulse(3, 6);
    rd(ad(3, 2), d); chk("R4 events", d, 1);
    @(negedge clk);
    evt[3] = 1'b1; bus_wr = 1'b1; bus_addr = ad(3, 2); bus_wdata = 2;
    @(negedge clk);
    evt[3] = 1'b0; bus_wr = 1'b0;
    rd(ad(3, 2), d); chk("R4 event with return", d, 0);
    wr(ad(3, 2), 0);
    rd(ad(3, 1), d); chk("R5 zero write mask", d, 1);
    rd(ad(3, 2), d); chk("R5 zero write credits", d, 0);
    chk("R7 masked no irq", 32'(irq_out), 0);
  endtask

  task automatic t_flags;
    logic [31:0] d;
    tick_div = 3;
    wr(ad(0, 0), 5);
    wr(ad(0, 2), 32'h0002_0000);
    rd(ad(0, 4), d); chk("R5 restart load", d, 5);
    rd(ad(0, 1), d); chk("R5 restart keeps mask", d, 1);
    repeat (16) @(negedge clk);
    rd(ad(0, 4), d); chk("R6 four ticks", d, 1);
    repeat (8) @(negedge clk);
    rd(ad(0, 4), d); chk("R6 reaches zero", d, 0);
    repeat (8) @(negedge clk);
    rd(ad(0, 4), d); chk("R6 stays zero", d, 0);
    wr(ad(0, 2), 32'h0001_0000);
    rd(ad(0, 1), d); chk("R5 unmask", d, 0);
    @(negedge clk);
    chk("R7 no credits no irq", 32'(irq_out), 0);
    wr(ad(0, 1), 1);
  endtask

  task automatic t_irq_now;
    logic [31:0] d;
    tick_div = 0;
    pulse(1, 3);
    chk("R7 masked", 32'(irq_out), 0);
    wr(ad(1, 2), 32'h0001_0000);
    chk("R7 not yet", 32'(irq_out), 0);
    @(negedge clk);
    chk("R7 pulse", 32'(irq_out), 32'h2);
    @(negedge clk);
    chk("R7 pulse ends", 32'(irq_out), 0);
    rd(ad(1, 1), d); chk("R7 mask reloaded", d, 1);
    rd(ad(1, 2), d); chk("R4 credits kept", d, 3);
  endtask

  task automatic t_irq_coal;
    logic [31:0] d;
    tick_div = 0;
    pulse(2, 2);
    wr(ad(2, 0), 6);
    wr(ad(2, 2), 32'h0003_0000);
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      chk("R7 coalesced timing", 32'(irq_out), (k == 7) ? 32'h4 : 32'h0);
    end
    rd(ad(2, 1), d); chk("R7 mask after fire", d, 1);
  endtask

  task automatic t_level;
    logic [31:0] d;
    wr(ad(2, 3), 0);
    wr(ad(2, 2), 32'h0001_0000);
    @(negedge clk); chk("R7 level 1", 32'(irq_out), 32'h4);
    @(negedge clk); chk("R7 level 2", 32'(irq_out), 32'h4);
    wr(ad(2, 2), 2);
    @(negedge clk); chk("R7 level off", 32'(irq_out), 0);
    rd(ad(2, 1), d); chk("R7 mask stays clear", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clamp();
    t_reserved();
    t_range();
    t_credits();
    t_flags();
    t_irq_now();
    t_irq_coal();
    t_level();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule